// File: doc/BRIEF.md
# Token-Passing Column Readout Sequencer

This block collects the hits of one triggered event from a row of column buffers and streams them to a link FIFO as 24-bit words. When an event is pending, the sequencer takes it on its own. It latches the event number and the bunch-crossing number and writes a start word. It then hands a token to each column that holds data, in ascending column order, and skips every column whose empty flag is set. The token-holding column drives 16-bit words onto a shared bus. Each word is prefixed with the 8-bit column number and written to the FIFO. The column marks its final word with an end-of-column flag.

When the token has passed the last column, the sequencer writes an end word carrying the number of data words in the event. It pulses a ready strobe and returns to idle. Every write is held back while the FIFO reports busy, so the serial link sets the pace of the whole readout. A word that is waiting stays on the bus and is never dropped.

The control is a five-state machine.
- `ST_IDLE` goes to `ST_HEAD` when an event is pending.
- `ST_HEAD` goes to `ST_SCAN` once the start word is written.
- `ST_SCAN` goes to `ST_XFER` if a non-empty column exists at or above the current index. Otherwise it goes to `ST_TAIL`.
- `ST_XFER` goes back to `ST_SCAN` after the end-of-column word of a column that is not the last. It goes to `ST_TAIL` after that word in the last column.
- `ST_TAIL` goes to `ST_IDLE` once the end word is written.

Top module: `col_readout_seq`

## Requirements
- R1: After reset the sequencer is idle. While `evt_pend` is low, `link_wr`, `tok_vld`, `evt_take` and `evt_done` are all low.
- R2: In idle with `evt_pend` high, `evt_take` pulses for one cycle without any start command. The event ID and bunch ID are latched in that cycle.
- R3: The first word of each event is the start word {8'hFF, event ID[4:0], bunch ID[10:0]}.
- R4: The token (`tok_vld`, `tok_col`) visits non-empty columns only, in ascending order. A column whose `col_empty` bit is 1 is never given the token and contributes no word.
- R5: Each data word is {column number zero-extended to 8 bits, 16-bit column data}. The words appear in the order the column presents them.
- R6: The token stays on a column until that column's word flagged `col_eoc` is accepted. While no word is accepted, `tok_col` does not change.
- R7: After the last column the end word {8'hFE, count of data words in the event} is written.
- R8: No word is written while `link_busy` is high. No word is lost or repeated across busy stretches.
- R9: An event in which every column is empty produces exactly a start word followed by an end word of count 0.
- R10: `evt_done` pulses in the cycle the end word is written. A new start word is never written before the previous end word.
- R11: `col_pop` is high only in a cycle where the token-holder's word is written to the link (`link_wr`, `col_dv`, `tok_vld` all high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_pend | input | 1 | A triggered event waits to be read out |
| evt_id | input | 5 | Event number of the pending event |
| evt_bid | input | 11 | Bunch-crossing number of the pending event |
| evt_take | output | 1 | Pending event accepted (pop strobe) |
| col_empty | input | N_COLS | Per-column empty flag, 1 = no data |
| tok_vld | output | 1 | Token is held by column `tok_col` |
| tok_col | output | IDX_W | Index of the token-holding column |
| col_dv | input | 1 | Shared bus carries a valid word |
| col_data | input | 16 | Shared column readout bus |
| col_eoc | input | 1 | Current bus word is the column's last |
| col_pop | output | 1 | Current bus word consumed |
| link_busy | input | 1 | Link FIFO cannot take a word |
| link_wr | output | 1 | Write strobe into the link FIFO |
| link_word | output | 24 | Word written to the link FIFO |
| evt_done | output | 1 | Event complete, ready for the next |

## Verification
Several properties are checked on every cycle:
- no write while busy;
- a column pop only together with a link write;
- the token never resting on an empty column;
- the token holding still while its word waits;
- the ready pulse landing on the end word;
- no second start word inside an open event.

Only the bench's scenarios can show that the stream has the right content in the right order. That covers skipped columns, column tagging, header fields and the word count in the end word. The bench sweeps every empty-column pattern of an eight-column configuration under three busy patterns, and compares the stream word by word with a list computed from the requirements.

// File: rtl/col_seq_pkg.sv
`timescale 1ns/1ps
package col_seq_pkg;

    localparam int TAG_W = 8;
    localparam logic [TAG_W-1:0] TAG_SOE = 8'hFF;
    localparam logic [TAG_W-1:0] TAG_EOE = 8'hFE;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEAD,
        ST_SCAN,
        ST_XFER,
        ST_TAIL
    } seq_state_e;

    typedef enum logic [1:0] {
        WK_NONE,
        WK_HEAD,
        WK_DATA,
        WK_TAIL
    } word_kind_e;

endpackage

// File: rtl/next_col_finder.sv
`timescale 1ns/1ps
// Lowest non-empty column at or above start_idx.
module next_col_finder #(
    parameter int N_COLS = 256,
    parameter int IDX_W  = 8
) (
    input  logic [N_COLS-1:0] empty,
    input  logic [IDX_W-1:0]  start_idx,
    output logic              found,
    output logic [IDX_W-1:0]  idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        // Descending walk: the last hit assigned is the lowest index.
        for (int i = N_COLS - 1; i >= 0; i--) begin
            if ((i >= int'(start_idx)) && !empty[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/link_word_packer.sv
`timescale 1ns/1ps
// Forms the 24-bit link word for the kind selected by the sequencer.
module link_word_packer
    import col_seq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 8
) (
    input  word_kind_e               kind,
    input  logic [IDX_W-1:0]         col_idx,
    input  logic [DATA_W-1:0]        col_data,
    input  logic [DATA_W-1:0]        header,
    input  logic [DATA_W-1:0]        count,
    output logic [TAG_W+DATA_W-1:0]  word
);
    logic [TAG_W-1:0] col_tag;

    generate
        if (IDX_W < TAG_W) begin : g_pad
            assign col_tag = {{(TAG_W - IDX_W){1'b0}}, col_idx};
        end else begin : g_nopad
            assign col_tag = col_idx[TAG_W-1:0];
        end
    endgenerate

    always_comb begin
        unique case (kind)
            WK_HEAD: word = {TAG_SOE, header};
            WK_DATA: word = {col_tag, col_data};
            WK_TAIL: word = {TAG_EOE, count};
            default: word = '0;
        endcase
    end
endmodule

// File: rtl/col_readout_seq.sv
`timescale 1ns/1ps
module col_readout_seq
    import col_seq_pkg::*;
#(
    parameter int N_COLS = 256,
    parameter int DATA_W = 16,
    parameter int BID_W  = 11,
    parameter int IDX_W  = (N_COLS > 1) ? $clog2(N_COLS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    evt_pend,
    input  logic [DATA_W-BID_W-1:0] evt_id,
    input  logic [BID_W-1:0]        evt_bid,
    output logic                    evt_take,
    input  logic [N_COLS-1:0]       col_empty,
    output logic                    tok_vld,
    output logic [IDX_W-1:0]        tok_col,
    input  logic                    col_dv,
    input  logic [DATA_W-1:0]       col_data,
    input  logic                    col_eoc,
    output logic                    col_pop,
    input  logic                    link_busy,
    output logic                    link_wr,
    output logic [TAG_W+DATA_W-1:0] link_word,
    output logic                    evt_done
);
    localparam int EID_W = DATA_W - BID_W;
    localparam logic [IDX_W-1:0] LAST_COL = IDX_W'(N_COLS - 1);

    seq_state_e        state_q, state_d;
    logic [IDX_W-1:0]  col_q;
    logic [DATA_W-1:0] cnt_q;
    logic [DATA_W-1:0] hdr_q;

    logic              nxt_found;
    logic [IDX_W-1:0]  nxt_idx;
    word_kind_e        kind;
    logic              accept_data;

    next_col_finder #(
        .N_COLS (N_COLS),
        .IDX_W  (IDX_W)
    ) u_finder (
        .empty     (col_empty),
        .start_idx (col_q),
        .found     (nxt_found),
        .idx       (nxt_idx)
    );

    link_word_packer #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_packer (
        .kind     (kind),
        .col_idx  (col_q),
        .col_data (col_data),
        .header   (hdr_q),
        .count    (cnt_q),
        .word     (link_word)
    );

    assign accept_data = (state_q == ST_XFER) && col_dv && !link_busy;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (evt_pend)   state_d = ST_HEAD;
            ST_HEAD: if (!link_busy) state_d = ST_SCAN;
            ST_SCAN: state_d = nxt_found ? ST_XFER : ST_TAIL;
            ST_XFER: if (accept_data && col_eoc)
                         state_d = (col_q == LAST_COL) ? ST_TAIL : ST_SCAN;
            ST_TAIL: if (!link_busy) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and event context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            col_q   <= '0;
            cnt_q   <= '0;
            hdr_q   <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: if (evt_pend) begin
                    hdr_q <= {EID_W'(evt_id), evt_bid};
                    cnt_q <= '0;
                    col_q <= '0;
                end
                ST_SCAN: if (nxt_found) col_q <= nxt_idx;
                ST_XFER: if (accept_data) begin
                    cnt_q <= cnt_q + 1'b1;
                    if (col_eoc && (col_q != LAST_COL)) col_q <= col_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        evt_take = 1'b0;
        tok_vld  = 1'b0;
        col_pop  = 1'b0;
        link_wr  = 1'b0;
        evt_done = 1'b0;
        kind     = WK_NONE;
        unique case (state_q)
            ST_IDLE: evt_take = evt_pend;
            ST_HEAD: begin
                kind    = WK_HEAD;
                link_wr = !link_busy;
            end
            ST_SCAN: ;
            ST_XFER: begin
                kind    = WK_DATA;
                tok_vld = 1'b1;
                link_wr = accept_data;
                col_pop = accept_data;
            end
            ST_TAIL: begin
                kind     = WK_TAIL;
                link_wr  = !link_busy;
                evt_done = !link_busy;
            end
            default: ;
        endcase
    end

    assign tok_col = col_q;

endmodule

// File: rtl/col_readout_seq_chk.sv
`timescale 1ns/1ps
module col_readout_seq_chk
    import col_seq_pkg::*;
#(
    parameter int N_COLS = 256,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    evt_pend,
    input logic                    evt_take,
    input logic [N_COLS-1:0]       col_empty,
    input logic                    tok_vld,
    input logic [IDX_W-1:0]        tok_col,
    input logic                    col_dv,
    input logic                    col_pop,
    input logic                    link_busy,
    input logic                    link_wr,
    input logic [TAG_W+DATA_W-1:0] link_word,
    input logic                    evt_done
);
    logic [TAG_W-1:0] tag;
    logic             soe_wr, eoe_wr, open_q;

    assign tag    = link_word[TAG_W+DATA_W-1:DATA_W];
    assign soe_wr = link_wr && !tok_vld && (tag == TAG_SOE);
    assign eoe_wr = link_wr && !tok_vld && (tag == TAG_EOE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      open_q <= 1'b0;
        else if (soe_wr) open_q <= 1'b1;
        else if (eoe_wr) open_q <= 1'b0;
    end

    // R8
    no_write_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_busy |-> !link_wr);

    // R11
    pop_with_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        col_pop |-> (link_wr && col_dv && tok_vld));

    // R4
    token_on_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tok_vld |-> !col_empty[tok_col]);

    // R6
    token_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_vld && !col_pop) |=> (tok_vld && $stable(tok_col)));

    // R10
    done_with_trailer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_done |-> eoe_wr);

    // R10
    single_open_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soe_wr |-> !open_q);

    // R2
    take_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_take |-> evt_pend);

endmodule

bind col_readout_seq col_readout_seq_chk #(
    .N_COLS (N_COLS),
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_pend  (evt_pend),
    .evt_take  (evt_take),
    .col_empty (col_empty),
    .tok_vld   (tok_vld),
    .tok_col   (tok_col),
    .col_dv    (col_dv),
    .col_pop   (col_pop),
    .link_busy (link_busy),
    .link_wr   (link_wr),
    .link_word (link_word),
    .evt_done  (evt_done)
);

// File: tb/test_col_readout_seq.sv
`timescale 1ns/1ps
module test_col_readout_seq;
    localparam int NC = 8;
    localparam int IW = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_pend = 1'b0;
    logic [4:0]  evt_id = '0;
    logic [10:0] evt_bid = '0;
    logic        evt_take;
    logic [NC-1:0] col_empty = '1;
    logic        tok_vld;
    logic [IW-1:0] tok_col;
    logic        col_dv;
    logic [15:0] col_data;
    logic        col_eoc;
    logic        col_pop;
    logic        link_busy = 1'b0;
    logic        link_wr;
    logic [23:0] link_word;
    logic        evt_done;

    int n_chk = 0;
    int n_bad = 0;
    int ev = 0;
    int busy_mode = 0;
    int cyc = 0;
    int nw [NC];
    int rd [NC];
    logic [23:0] exp_q [$];
    int exp_i = 0;
    logic done_seen = 1'b0;
    logic in_evt = 1'b0;

    always #5 clk = ~clk;

    col_readout_seq #(.N_COLS(NC), .DATA_W(16), .BID_W(11)) i_col_readout_seq (
        .clk(clk), .rst_n(rst_n), .evt_pend(evt_pend), .evt_id(evt_id),
        .evt_bid(evt_bid), .evt_take(evt_take), .col_empty(col_empty),
        .tok_vld(tok_vld), .tok_col(tok_col), .col_dv(col_dv),
        .col_data(col_data), .col_eoc(col_eoc), .col_pop(col_pop),
        .link_busy(link_busy), .link_wr(link_wr), .link_word(link_word),
        .evt_done(evt_done)
    );

    function automatic logic [15:0] fdat(int e, int c, int k);
        return 16'(e * 97 + c * 11 + k * 3 + 16'h0400);
    endfunction

    task automatic check(string req, logic ok, logic [23:0] act, logic [23:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (event %0d)", req, act, expv, ev);
        end
    endtask

    // Column buffer model: the token holder presents its words one by one
    always_comb begin
        col_dv   = 1'b0;
        col_data = '0;
        col_eoc  = 1'b0;
        if (tok_vld && rd[tok_col] < nw[tok_col]) begin
            col_dv   = 1'b1;
            col_data = fdat(ev, int'(tok_col), rd[tok_col]);
            col_eoc  = (rd[tok_col] == nw[tok_col] - 1);
        end
    end

    always @(posedge clk) begin
        if (evt_take) begin
            for (int c = 0; c < NC; c++) rd[c] <= 0;
        end else if (col_pop) begin
            rd[tok_col] <= rd[tok_col] + 1;
        end
    end

    // Link busy patterns, driven just after the edge
    always @(posedge clk) begin
        #1;
        cyc++;
        case (busy_mode)
            0: link_busy <= 1'b0;
            1: link_busy <= (cyc % 3) == 0;
            default: link_busy <= ((cyc * 7) % 11) < 5;
        endcase
    end

    // Monitor, sampled at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (link_wr) begin
                // R8
                check("R8", !link_busy, {23'd0, link_busy}, 24'd0);
                if (exp_i < exp_q.size()) begin
                    if (exp_i == 0)
                        check("R3", link_word == exp_q[exp_i], link_word, exp_q[exp_i]);
                    else if (exp_i == exp_q.size() - 1)
                        check("R7", link_word == exp_q[exp_i], link_word, exp_q[exp_i]);
                    else
                        check("R5", link_word == exp_q[exp_i], link_word, exp_q[exp_i]);
                end else begin
                    check("R10", 1'b0, link_word, 24'hxxxxxx);
                end
                // R10: ready exactly with the end word
                check("R10", evt_done == (exp_i == exp_q.size() - 1),
                      {23'd0, evt_done}, {23'd0, exp_i == exp_q.size() - 1});
                exp_i++;
            end else if (evt_done) begin
                check("R10", 1'b0, 24'd1, 24'd0);
            end
            if (col_pop) begin
                // R11
                check("R11", link_wr && col_dv, {22'd0, link_wr, col_dv}, 24'd3);
            end
            if (tok_vld) begin
                // R4
                check("R4", !col_empty[tok_col], {21'd0, tok_col}, 24'd0);
            end
            if (evt_done) done_seen = 1'b1;
        end
    end

    task automatic run_event(logic [NC-1:0] mask, int mode);
        int total = 0;
        @(posedge clk);
        #2;
        ev++;
        busy_mode = mode;
        col_empty = mask;
        for (int c = 0; c < NC; c++) nw[c] = ((c + ev) % 3) + 1;
        evt_id  = 5'(ev);
        evt_bid = 11'(ev * 13 + 5);
        exp_q.delete();
        exp_i = 0;
        exp_q.push_back({8'hFF, 5'(ev), 11'(ev * 13 + 5)});
        for (int c = 0; c < NC; c++) begin
            if (!mask[c]) begin
                for (int k = 0; k < nw[c]; k++) begin
                    exp_q.push_back({8'(c), fdat(ev, c, k)});
                    total++;
                end
            end
        end
        exp_q.push_back({8'hFE, 16'(total)});
        done_seen = 1'b0;
        evt_pend  = 1'b1;
        // R2: taken in the idle cycle with no start command
        @(negedge clk);
        #1;
        check("R2", evt_take, {23'd0, evt_take}, 24'd1);
        @(posedge clk);
        #2;
        evt_pend = 1'b0;
        while (!done_seen) begin
            @(negedge clk);
            #1;
        end
        // R7/R9: all expected words seen, nothing more
        if (mask == '1)
            check("R9", exp_i == 2, 24'(exp_i), 24'd2);
        else
            check("R7", exp_i == exp_q.size(), 24'(exp_i), 24'(exp_q.size()));
    endtask

    initial begin : watchdog
        #1500000;
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        for (int c = 0; c < NC; c++) begin
            nw[c] = 1;
            rd[c] = 0;
        end
        repeat (3) @(posedge clk);
        #2;
        // R1 during reset
        check("R1", !link_wr && !tok_vld && !evt_take && !evt_done,
              {20'd0, link_wr, tok_vld, evt_take, evt_done}, 24'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1 after reset, nothing pending
        check("R1", !link_wr && !tok_vld && !evt_take && !evt_done,
              {20'd0, link_wr, tok_vld, evt_take, evt_done}, 24'd0);
        // R9: fully empty event first, then every mask under three busy patterns
        run_event('1, 0);
        for (int m = 0; m < (1 << NC); m++) begin
            run_event(NC'(m), m % 3);
        end
        // R6: token holds through a long busy stretch
        run_event(8'b1110_1101, 2);
        repeat (4) @(negedge clk);
        check("R1", !tok_vld && !link_wr, {22'd0, tok_vld, link_wr}, 24'd0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule